// File: doc/BRIEF.md
# Guarded Register Write Sequencer

This block sits between a host write port and a register bank that runs from a slow clock and needs time to absorb each update. Writes to such a bank can be lost. To make them stick, every host write is preceded by two zero-valued writes to the bank's status register. Writing zero there has no side effect, because status bits clear only when a one is written to them.

The host offers a request with an address and data using a valid/ready handshake. The sequencer accepts one request at a time and emits three single-cycle write strobes on consecutive cycles. The first two go to the status address with zero data, and the third carries the captured request. It then holds the host off for a settling interval that covers 5 µs at the configured bus clock. When the interval ends it pulses a done flag, and in that same cycle it is ready for the next request.

The settling length is derived at elaboration from the clock frequency and the required settle time, rounded up to whole cycles. The status address is a parameter and defaults to zero.

Top module: `guarded_write_seq`

## Requirements
- R1: During and right after a synchronous active-low reset, `req_ready` is 1, `wr_stb` is 0 and `done` is 0.
- R2: In the two cycles after a request is accepted (`req_valid` and `req_ready` both high at a clock edge), `wr_stb` is 1 with `wr_addr` equal to `STATUS_ADDR` (default 0) and `wr_data` equal to 0.
- R3: In the third cycle after acceptance, `wr_stb` is 1 and `wr_addr`/`wr_data` equal the request address and data sampled at the accepting edge. Later changes on the request inputs have no effect on that write.
- R4: Each acceptance produces exactly three strobes, on three consecutive cycles, each one cycle long.
- R5: From acceptance until the end of the hold-off, `req_ready` is 0. During the hold-off, `wr_stb` stays 0.
- R6: The hold-off lasts ceil(`CLK_HZ` × `SETTLE_NS` / 10^9) cycles, with a minimum of 1, counted from the cycle after the real write.
- R7: `done` is a one-cycle pulse in the first cycle after the hold-off. In that cycle `req_ready` is 1 again.
- R8: `req_valid` with `req_ready` low is ignored. With `req_valid` low, no strobe is issued.
- R9: A request held valid through the done cycle is accepted at that cycle's closing edge, with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host write request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_addr | input | ADDR_W | Requested register offset |
| req_data | input | DATA_W | Requested write data |
| wr_stb | output | 1 | Downstream write strobe, one cycle per write |
| wr_addr | output | ADDR_W | Downstream write address |
| wr_data | output | DATA_W | Downstream write data |
| done | output | 1 | Pulse when the hold-off after a write expires |

## Verification
All timing is counted from the accepting clock edge, called edge 0:

| Result | When it is due |
|---|---|
| Dummy strobes | cycles 1 and 2 |
| Real strobe | cycle 3 |
| Hold-off | cycles 4 to 3+N, where N is the hold-off length |
| `done` and `req_ready` | cycle 4+N |

The bench drives inputs and samples outputs on the falling edge. After each acceptance it walks these cycles one falling edge at a time and checks each cycle against this schedule. The hold-off length is therefore measured exactly rather than bounded. The bench also changes the request inputs while the sequencer is busy, to show that they are ignored and that a request held valid is taken in the done cycle.

// File: rtl/gws_pkg.sv
// Package: shared types for the guarded write sequencer.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package gws_pkg;

    // Phase of the write sequence, from idle through the hold-off.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_DUMMY0 = 3'd1,
        PH_DUMMY1 = 3'd2,
        PH_REAL   = 3'd3,
        PH_HOLD   = 3'd4
    } gws_phase_t;

endpackage

// File: rtl/gws_settle_timer.sv
// Module: gws_settle_timer
// Counts a fixed number of cycles after a start pulse and flags the last one.
// Assumes CYCLES >= 1 and that start is never raised while a count is running.
module gws_settle_timer #(
    parameter int CYCLES = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expire
);
    localparam int CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES - 1);

    logic             running;
    logic [CNT_W-1:0] cnt;

    // Load the count on start, then count down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (start) begin
            running <= 1'b1;
            cnt     <= LOAD;
        end else if (running) begin
            if (cnt == '0) running <= 1'b0;
            else           cnt     <= cnt - 1'b1;
        end
    end

    // The final cycle of the running window is the expiry cycle.
    assign expire = running && (cnt == '0);

    // R5
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !running);
    // R6
    expire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire);
endmodule

// File: rtl/gws_seq_fsm.sv
// Module: gws_seq_fsm
// Accepts one host write, issues two zero writes to the status address and then
// the captured write, and waits for the settle timer before accepting again.
// Assumes hold_expire is a one-cycle pulse from a timer started by hold_start.
module gws_seq_fsm
    import gws_pkg::*;
#(
    parameter int               ADDR_W      = 8,
    parameter int               DATA_W      = 32,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              hold_expire,
    output logic              hold_start,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              done
);
    gws_phase_t        phase, phase_nx;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              done_q;
    logic              accept;

    assign req_ready = (phase == PH_IDLE);
    assign accept    = req_valid && req_ready;

    // Choose the following phase of the sequence.
    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_IDLE:   if (accept) phase_nx = PH_DUMMY0;
            PH_DUMMY0: phase_nx = PH_DUMMY1;
            PH_DUMMY1: phase_nx = PH_REAL;
            PH_REAL:   phase_nx = PH_HOLD;
            PH_HOLD:   if (hold_expire) phase_nx = PH_IDLE;
            default:   phase_nx = PH_IDLE;
        endcase
    end

    // Advance the phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= phase_nx;
    end

    // Capture the request payload at acceptance only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (accept) begin
            addr_q <= req_addr;
            data_q <= req_data;
        end
    end

    // Raise done for one cycle after the hold-off ends.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= (phase == PH_HOLD) && hold_expire;
    end

    // Drive the downstream write bus from the phase.
    always_comb begin
        wr_stb  = (phase == PH_DUMMY0) || (phase == PH_DUMMY1) || (phase == PH_REAL);
        wr_addr = (phase == PH_REAL) ? addr_q : STATUS_ADDR;
        wr_data = (phase == PH_REAL) ? data_q : '0;
    end

    assign hold_start = (phase == PH_REAL);
    assign done       = done_q;

    // R2
    dummy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (wr_stb && wr_addr == STATUS_ADDR && wr_data == '0)
                   ##1 (wr_stb && wr_addr == STATUS_ADDR && wr_data == '0));
    // R3
    real_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ##2 (wr_stb && wr_addr == $past(req_addr, 3)
                                 && wr_data == $past(req_data, 3)));
    // R4
    three_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_stb) |=> wr_stb ##1 wr_stb ##1 !wr_stb);
endmodule

// File: rtl/guarded_write_seq.sv
// Module: guarded_write_seq (top)
// Wraps every host register write in two zero writes to the status address and
// a settling hold-off sized from the bus clock frequency.
// Assumes the status register ignores zero writes and CLK_HZ * SETTLE_NS fits 64 bits.
module guarded_write_seq #(
    parameter int                ADDR_W      = 8,
    parameter int                DATA_W      = 32,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = '0,
    parameter longint            CLK_HZ      = 100_000_000,
    parameter longint            SETTLE_NS   = 5_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              done
);
    localparam longint RAW_CYC    = (CLK_HZ * SETTLE_NS + 64'd999_999_999) / 64'd1_000_000_000;
    localparam int     SETTLE_CYC = (RAW_CYC < 1) ? 1 : int'(RAW_CYC);

    logic hold_start;
    logic hold_expire;

    gws_seq_fsm #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .STATUS_ADDR (STATUS_ADDR)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_addr    (req_addr),
        .req_data    (req_data),
        .hold_expire (hold_expire),
        .hold_start  (hold_start),
        .wr_stb      (wr_stb),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .done        (done)
    );

    gws_settle_timer #(
        .CYCLES (SETTLE_CYC)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (hold_start),
        .expire (hold_expire)
    );

    // R5
    busy_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> !req_ready);
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7
    done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);
endmodule

// File: tb/tb_guarded_write_seq.sv
module tb_guarded_write_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 32;
    // 4 MHz bus clock and 5000 ns settle: 4e6 * 5e-6 = 20 cycles.
    localparam int HOLD = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          wr_stb;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic          done;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    guarded_write_seq #(
        .ADDR_W (AW), .DATA_W (DW), .STATUS_ADDR ('0),
        .CLK_HZ (4_000_000), .SETTLE_NS (5_000)
    ) dut (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
        .req_addr (req_addr), .req_data (req_data), .wr_stb (wr_stb),
        .wr_addr (wr_addr), .wr_data (wr_data), .done (done)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Walk one sequence from the accepting edge; at the first falling edge,
    // load the request inputs with nxt_* and keep_valid.
    task automatic run_seq(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input bit keep_valid,
                           input logic [AW-1:0] nxt_a, input logic [DW-1:0] nxt_d);
        @(negedge clk);
        check(wr_stb == 1'b1, "R2 dummy0 stb", wr_stb, 1);
        check(wr_addr == '0 && wr_data == '0, "R2 dummy0 payload", {wr_addr, wr_data}, 0);
        check(req_ready == 1'b0, "R5 busy after accept", req_ready, 0);
        req_valid = keep_valid;
        req_addr  = nxt_a;
        req_data  = nxt_d;
        @(negedge clk);
        check(wr_stb == 1'b1, "R4 dummy1 stb", wr_stb, 1);
        check(wr_addr == '0 && wr_data == '0, "R2 dummy1 payload", {wr_addr, wr_data}, 0);
        @(negedge clk);
        check(wr_stb == 1'b1, "R4 real stb", wr_stb, 1);
        check(wr_addr == a, "R3 real addr", wr_addr, a);
        check(wr_data == d, "R3 real data", wr_data, d);
        for (int i = 0; i < HOLD; i++) begin
            @(negedge clk);
            check(!wr_stb && !req_ready && !done, "R5 hold-off quiet",
                  {wr_stb, req_ready, done}, 0);
        end
        @(negedge clk);
        check(req_ready == 1'b1, "R6 ready after hold-off", req_ready, 1);
        check(done == 1'b1, "R7 done pulse", done, 1);
    endtask

    task automatic issue(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_data  = d;
        @(posedge clk);
        run_seq(a, d, 1'b0, 8'h00, 32'h0);
        @(negedge clk);
        check(done == 1'b0, "R7 done one cycle", done, 0);
        check(wr_stb == 1'b0, "R8 no strobe while idle", wr_stb, 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
        check(wr_stb == 1'b0, "R1 stb in reset", wr_stb, 0);
        check(done == 1'b0, "R1 done in reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && wr_stb == 1'b0 && done == 1'b0, "R1 after reset",
              {req_ready, wr_stb, done}, 3'b100);
    endtask

    task automatic t_idle_quiet();
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            req_addr = 8'(i + 3);
            check(wr_stb == 1'b0, "R8 valid low gives no strobe", wr_stb, 0);
        end
    endtask

    task automatic t_busy_then_back_to_back();
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = 8'h1C;
        req_data  = 32'hCAFE_0001;
        @(posedge clk);
        // Valid stays high with new fields while busy: ignored until the done cycle (R8, R9).
        run_seq(8'h1C, 32'hCAFE_0001, 1'b1, 8'h44, 32'h0BAD_F00D);
        @(posedge clk);
        run_seq(8'h44, 32'h0BAD_F00D, 1'b0, 8'h00, 32'h0);
        @(negedge clk);
        check(done == 1'b0 && wr_stb == 1'b0, "R9 second sequence only", {done, wr_stb}, 0);
    endtask

    task automatic run_all();
        t_reset();
        t_idle_quiet();
        issue(8'h0C, 32'h1234_5678);
        issue(8'hFF, 32'hFFFF_FFFF);
        issue(8'h00, 32'h0000_0003);
        t_busy_then_back_to_back();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (5000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule